// File: doc/BRIEF.md
# Transmit Level Current-Limit Controller

This block owns the digital amplitude code that sets the gain stage in front of the transmit DAC. At the start of every transmission it loads a configured target code. After that it backs the code off by itself whenever the line driver's current-sense comparator reports an overcurrent. The backoff loop has hysteresis. A high-threshold flag starts the reduction, and the code then falls by one step on each step tick. It keeps falling until a low-threshold flag reports that the sensed level has dropped far enough, and from then on the code holds.

Alongside the code, the block reports the equivalent attenuation in dB and a flag that shows the loop is currently limiting. It also produces an open-drain style select line for the external current-sense resistor. The line is pulled low for frequency-shift keying and released for phase-shift keying, so that a different limit resistor applies to each modulation.

The effective code and the limiting flag are registers, updated on the clock edge that samples the inputs. The attenuation value and the resistor-select pins are combinational. The attenuation follows the registered code, and the resistor-select pins follow the modulation input directly.

Top module: `txl_current_limit`

## Requirements
- R1: While synchronous reset `rst` is high, the registered outputs clear on the next edge: `gain_code` becomes 0 and `limiting` becomes 0.
- R2: `atten_db` always equals 31 minus `gain_code` (code 31 gives 0, meaning 0 dB of attenuation; code 0 gives 31, meaning -31 dB).
- R3: A cycle with `tx_start` high loads `cfg_gain` into `gain_code` and clears `limiting` on the next edge. This takes priority over every comparator and tick input in that cycle.
- R4: While `cmp_hi` is high, each cycle with `step_tick` high lowers `gain_code` by exactly one code. A cycle with `step_tick` low never changes `gain_code`, except through R3.
- R5: Once limiting has started, `gain_code` keeps falling by one per `step_tick` even with both comparator flags low, until `cmp_lo` is seen.
- R6: While `limiting` is high, a cycle with `cmp_lo` high and `cmp_hi` low clears `limiting` on the next edge and leaves `gain_code` unchanged. Further ticks with `cmp_hi` low then leave the code where it is.
- R7: When `cmp_hi` and `cmp_lo` are both high, `cmp_hi` wins. A tick in that cycle still steps the code down, and `limiting` stays high.
- R8: `gain_code` saturates at 0. A step requested at code 0 leaves it at 0 and never wraps to 31.
- R9: `limiting` rises on the same edge as the first downward step and stays high until the release of R6 or a reload under R3.
- R10: With `mod_psk` = 0 (frequency-shift keying), `rsel_oe` = 1 and `rsel_drive` = 0, so the line is driven low. With `mod_psk` = 1 (phase-shift keying), `rsel_oe` = 0, so the line is left to the external pull-up. `rsel_drive` is never 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_gain | input | 5 | Target gain code loaded at transmission start |
| tx_start | input | 1 | One-cycle strobe marking a new transmission |
| cmp_hi | input | 1 | Current sense above the high threshold |
| cmp_lo | input | 1 | Current sense below the low threshold |
| step_tick | input | 1 | Enables one backoff step in this cycle |
| mod_psk | input | 1 | Modulation select: 0 = frequency-shift keying, 1 = phase-shift keying |
| gain_code | output | 5 | Effective transmit gain code |
| atten_db | output | 5 | Attenuation magnitude in dB (31 - gain_code) |
| limiting | output | 1 | Current-limit backoff loop active |
| rsel_drive | output | 1 | Resistor-select output data (always low) |
| rsel_oe | output | 1 | Resistor-select output enable |

## Verification
The bench steers the loop through the stretch between the two thresholds, where both flags are low. A design without hysteresis would stop stepping there, and one that releases too eagerly would let the code hold early. It drives both flags at once to catch a design that lets the low flag win and drops `limiting` while still over current. It runs the code into zero to expose a decrement that wraps to full scale. It strobes `tx_start` during an active backoff with a tick pending, to catch a reload that loses to the step or that leaves the limiting flag set. A sweep of every target code checks the attenuation mapping at both ends, and a toggle of the modulation input checks that the select line is driven low or released and never driven high.

// File: rtl/txl_pkg.sv
package txl_pkg;

    // Action chosen for the gain register in a given cycle.
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_RELOAD  = 2'd1,
        ACT_STEP    = 2'd2,
        ACT_RELEASE = 2'd3
    } txl_act_e;

    // Modulation family seen on the select input.
    typedef enum logic {
        MOD_FSK = 1'b0,
        MOD_PSK = 1'b1
    } txl_mod_e;

    // Open-drain style pin pair.
    typedef struct packed {
        logic drive;
        logic oe;
    } txl_od_t;

endpackage

// File: rtl/txl_step_ctrl.sv
module txl_step_ctrl
    import txl_pkg::*;
(
    input  logic     tx_start,
    input  logic     cmp_hi,
    input  logic     cmp_lo,
    input  logic     step_tick,
    input  logic     limiting,
    output txl_act_e act
);

    logic over_current;
    logic keep_falling;
    logic want_step;
    logic want_release;

    // The high flag dominates; between thresholds an active loop keeps going.
    assign over_current = cmp_hi;
    assign keep_falling = limiting && !cmp_lo;
    assign want_step    = step_tick && (over_current || keep_falling);
    assign want_release = limiting && cmp_lo && !over_current;

    always_comb begin
        if (tx_start) begin
            act = ACT_RELOAD;
        end else if (want_step) begin
            act = ACT_STEP;
        end else if (want_release) begin
            act = ACT_RELEASE;
        end else begin
            act = ACT_HOLD;
        end
    end

endmodule

// File: rtl/txl_gain_reg.sv
module txl_gain_reg
    import txl_pkg::*;
#(
    parameter int GAIN_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  txl_act_e          act,
    input  logic [GAIN_W-1:0] cfg_gain,
    output logic [GAIN_W-1:0] gain,
    output logic              limiting
);

    localparam logic [GAIN_W-1:0] FLOOR = '0;
    localparam logic [GAIN_W-1:0] ONE   = GAIN_W'(1);

    logic [GAIN_W-1:0] next_down;

    assign next_down = (gain == FLOOR) ? FLOOR : (gain - ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            gain     <= FLOOR;
            limiting <= 1'b0;
        end else begin
            unique case (act)
                ACT_RELOAD: begin
                    gain     <= cfg_gain;
                    limiting <= 1'b0;
                end
                ACT_STEP: begin
                    gain     <= next_down;
                    limiting <= 1'b1;
                end
                ACT_RELEASE: begin
                    limiting <= 1'b0;
                end
                default: begin
                end
            endcase
        end
    end

    // R9: a step always leaves the loop marked active
    a_r9_flag_on_step: assert property (@(posedge clk) disable iff (rst)
        act == ACT_STEP |=> limiting);

endmodule

// File: rtl/txl_atten.sv
module txl_atten #(
    parameter int GAIN_W = 5
) (
    input  logic [GAIN_W-1:0] gain,
    output logic [GAIN_W-1:0] atten
);

    localparam logic [GAIN_W-1:0] FULL_SCALE = '1;

    assign atten = FULL_SCALE - gain;

endmodule

// File: rtl/txl_rsel.sv
module txl_rsel
    import txl_pkg::*;
(
    input  logic mod_psk,
    output logic rsel_drive,
    output logic rsel_oe
);

    txl_mod_e mode;
    txl_od_t  pin;

    assign mode = txl_mod_e'(mod_psk);

    always_comb begin
        pin.drive = 1'b0;
        pin.oe    = (mode == MOD_FSK);
    end

    assign rsel_drive = pin.drive;
    assign rsel_oe    = pin.oe;

endmodule

// File: rtl/txl_current_limit.sv
module txl_current_limit
    import txl_pkg::*;
#(
    parameter int GAIN_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [GAIN_W-1:0] cfg_gain,
    input  logic              tx_start,
    input  logic              cmp_hi,
    input  logic              cmp_lo,
    input  logic              step_tick,
    input  logic              mod_psk,
    output logic [GAIN_W-1:0] gain_code,
    output logic [GAIN_W-1:0] atten_db,
    output logic              limiting,
    output logic              rsel_drive,
    output logic              rsel_oe
);

    localparam logic [GAIN_W-1:0] ONE = GAIN_W'(1);

    txl_act_e act;

    txl_step_ctrl u_ctrl (
        .tx_start  (tx_start),
        .cmp_hi    (cmp_hi),
        .cmp_lo    (cmp_lo),
        .step_tick (step_tick),
        .limiting  (limiting),
        .act       (act)
    );

    txl_gain_reg #(.GAIN_W(GAIN_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .cfg_gain (cfg_gain),
        .gain     (gain_code),
        .limiting (limiting)
    );

    txl_atten #(.GAIN_W(GAIN_W)) u_atten (
        .gain  (gain_code),
        .atten (atten_db)
    );

    txl_rsel u_rsel (
        .mod_psk    (mod_psk),
        .rsel_drive (rsel_drive),
        .rsel_oe    (rsel_oe)
    );

    // R3: a start strobe loads the target and clears the loop
    a_r3_reload: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> (gain_code == $past(cfg_gain)) && !limiting);

    // R4: without a tick and without a start the code is frozen
    a_r4_tick_gate: assert property (@(posedge clk) disable iff (rst)
        !tx_start && !step_tick |=> $stable(gain_code));

    // R4: outside a reload the code never moves by more than one
    a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
        !tx_start |=> (gain_code == $past(gain_code)) ||
                      (gain_code == $past(gain_code) - ONE));

    // R8: no wrap below the floor
    a_r8_floor: assert property (@(posedge clk) disable iff (rst)
        (gain_code == '0) && !tx_start |=> gain_code == '0);

    // R6: low flag alone releases the loop without touching the code
    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        limiting && cmp_lo && !cmp_hi && !tx_start
        |=> !limiting && $stable(gain_code));

    // R7: high flag wins over the low flag
    a_r7_hi_wins: assert property (@(posedge clk) disable iff (rst)
        cmp_hi && cmp_lo && step_tick && !tx_start |=> limiting);

    // R10: the select line is only ever pulled low
    a_r10_open_drain: assert property (@(posedge clk) disable iff (rst)
        rsel_oe |-> !rsel_drive);

endmodule

// File: tb/txl_current_limit_bench.sv
module txl_current_limit_bench;

    typedef struct {
        logic [4:0] gain;
        logic [4:0] atten;
        logic       lim;
        logic       oe;
        logic       drv;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] cfg_gain = '0;
    logic       tx_start = 1'b0;
    logic       cmp_hi = 1'b0;
    logic       cmp_lo = 1'b0;
    logic       step_tick = 1'b0;
    logic       mod_psk = 1'b0;
    logic [4:0] gain_code;
    logic [4:0] atten_db;
    logic       limiting;
    logic       rsel_drive;
    logic       rsel_oe;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    // model state
    logic [4:0] mg = '0;
    logic       ml = 1'b0;

    always #4 clk = ~clk;

    txl_current_limit u_txl_current_limit (
        .clk        (clk),
        .rst        (rst),
        .cfg_gain   (cfg_gain),
        .tx_start   (tx_start),
        .cmp_hi     (cmp_hi),
        .cmp_lo     (cmp_lo),
        .step_tick  (step_tick),
        .mod_psk    (mod_psk),
        .gain_code  (gain_code),
        .atten_db   (atten_db),
        .limiting   (limiting),
        .rsel_drive (rsel_drive),
        .rsel_oe    (rsel_oe)
    );

    task automatic drive(input logic r, input logic st, input logic [4:0] cfg,
                         input logic hi, input logic lo, input logic tk,
                         input logic psk, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; tx_start = st; cfg_gain = cfg;
        cmp_hi = hi; cmp_lo = lo; step_tick = tk; mod_psk = psk;
        if (r) begin
            mg = '0; ml = 1'b0;
        end else if (st) begin
            mg = cfg; ml = 1'b0;
        end else if (tk && (hi || (ml && !lo))) begin
            mg = (mg == 5'd0) ? 5'd0 : mg - 5'd1;
            ml = 1'b1;
        end else if (ml && lo && !hi) begin
            ml = 1'b0;
        end
        e.gain = mg; e.atten = 5'd31 - mg; e.lim = ml;
        e.oe = !psk; e.drv = 1'b0; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares one expected item per clock, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (gain_code !== e.gain || atten_db !== e.atten ||
                    limiting !== e.lim || rsel_oe !== e.oe ||
                    rsel_drive !== e.drv) begin
                    errors++;
                    $display("FAIL %s: got gain=%0d atten=%0d lim=%0b oe=%0b drv=%0b, expected gain=%0d atten=%0d lim=%0b oe=%0b drv=%0b",
                             e.tag, gain_code, atten_db, limiting, rsel_oe, rsel_drive,
                             e.gain, e.atten, e.lim, e.oe, e.drv);
                end
            end
        end
    end

    initial begin
        #1600000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        drive(1, 0, 5'd0, 0, 0, 0, 0, "R1");
        drive(1, 0, 5'd0, 0, 0, 0, 0, "R1");
        // R10: frequency-shift keying pulls the line low
        drive(0, 0, 5'd0, 0, 0, 0, 0, "R10");
        // R3: load full scale; R2: zero attenuation
        drive(0, 1, 5'd31, 0, 0, 0, 0, "R3");
        drive(0, 0, 5'd0, 0, 0, 0, 0, "R2");
        // R4: high flag without tick holds
        drive(0, 0, 5'd0, 1, 0, 0, 0, "R4");
        drive(0, 0, 5'd0, 1, 0, 0, 0, "R4");
        // R9 first step raises the flag, R4 further single steps
        drive(0, 0, 5'd0, 1, 0, 1, 0, "R9");
        drive(0, 0, 5'd0, 1, 0, 1, 0, "R4");
        drive(0, 0, 5'd0, 1, 0, 1, 0, "R4");
        // R5: between thresholds the loop keeps stepping
        drive(0, 0, 5'd0, 0, 0, 1, 0, "R5");
        drive(0, 0, 5'd0, 0, 0, 1, 0, "R5");
        drive(0, 0, 5'd0, 0, 0, 0, 0, "R5");
        // R6: low flag releases and the code holds afterwards
        drive(0, 0, 5'd0, 0, 1, 0, 0, "R6");
        drive(0, 0, 5'd0, 0, 1, 1, 0, "R6");
        drive(0, 0, 5'd0, 0, 0, 1, 0, "R6");
        // R7: both flags with a tick, high wins
        drive(0, 0, 5'd0, 1, 1, 1, 0, "R7");
        drive(0, 0, 5'd0, 1, 1, 0, 0, "R7");
        drive(0, 0, 5'd0, 0, 1, 0, 0, "R6");
        // R10: phase-shift keying releases the line
        drive(0, 0, 5'd0, 0, 0, 0, 1, "R10");
        drive(0, 0, 5'd0, 0, 0, 0, 0, "R10");
        // R8: saturate at zero
        drive(0, 1, 5'd2, 0, 0, 0, 1, "R3");
        drive(0, 0, 5'd0, 1, 0, 1, 1, "R8");
        drive(0, 0, 5'd0, 1, 0, 1, 1, "R8");
        drive(0, 0, 5'd0, 1, 0, 1, 1, "R8");
        drive(0, 0, 5'd0, 0, 0, 1, 1, "R8");
        // R3: reload beats a pending step and clears limiting
        drive(0, 1, 5'd17, 1, 0, 1, 0, "R3");
        drive(0, 0, 5'd0, 0, 0, 0, 0, "R3");
        // R2: attenuation across every code
        for (int c = 0; c < 32; c++) begin
            drive(0, 1, 5'(c), 0, 0, 0, c[0], "R2");
        end
        // R1: reset in the middle of a backoff
        drive(0, 0, 5'd0, 1, 0, 1, 0, "R9");
        drive(1, 0, 5'd0, 1, 0, 1, 0, "R1");
        drive(0, 0, 5'd0, 0, 0, 0, 0, "R1");
        while (sb.size() > 0) @(posedge clk);
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule